// File: doc/BRIEF.md
# Move-Eliminating Register Rename Stage

This block renames a group of up to `GROUP` decoded instructions each cycle. It keeps one table for scalar registers and one for vector registers, and each table maps an architectural register to a physical tag. Every slot carries a class code, an architectural destination, two architectural sources and an immediate. Within a group the slots are renamed in program order. A source read in a later slot takes the tag given by the latest earlier slot in the same domain that wrote that register.

Several kinds of instruction are settled here and never take an execution port. A register-to-register move makes its destination an alias of the source's physical tag. An immediate load takes a fresh tag and passes its immediate on with the renamed entry, so the value can be written without an ALU. A vector clear maps its destination to vector tag 0, which is hardwired to zero. A NOP is dropped. A chain of scalar moves in one group resolves to the original tag. A vector move whose source was last written by a vector move earlier in the same group is instead given a fresh tag and sent to execution. A scalar ALU operation whose two sources are the same register is renamed like any other ALU operation, so zeroing by xor of a register with itself keeps its true dependency.

The group is accepted with a valid/ready handshake. It stalls when the external free list holds fewer tags than the group needs in either domain, or when the registered output is full and not taken. On acceptance the block reports how many tags it took from each domain's free list.

Top module: `mv_rename`

## Requirements
- R1: After reset `out_valid` is 0 and every architectural register of both domains maps to physical tag 0, so the first sources read after reset give tag 0.
- R2: A slot of class 1 (scalar ALU) or class 4 (vector ALU) takes the next unused free-list tag of its domain, in slot order from `fl_*_tag[0]` upward. It has `out_exec` 1 and writes the new tag into its domain's map.
- R3: A source in slot i resolves to the tag assigned by the latest slot j<i of the same domain whose destination equals that source. Otherwise it resolves to the map entry. Scalar and vector registers with the same number never bypass to each other.
- R4: A slot of class 2 (scalar move) gets `out_pdst` equal to its resolved source-1 tag and `out_exec` 0, and it takes no tag. This holds for up to `GROUP` moves per group across both domains, even with both free-list counts at 0.
- R5: A scalar move whose source was written by an earlier scalar move in the group resolves to the tag that the first move aliased.
- R6: A slot of class 5 (vector move) is eliminated in the same way as in R4, unless the latest earlier in-group vector writer of its source is itself of class 5. In that case it takes a new vector tag and has `out_exec` 1.
- R7: A slot of class 3 (scalar immediate load) or class 7 (vector immediate load) takes a new tag of its domain and has `out_exec` 0. Its `in_imm` appears on `out_imm`.
- R8: A slot of class 6 (vector clear) gets vector tag 0 as `out_pdst`, has `out_exec` 0, takes no tag, and later readers of that register see tag 0.
- R9: A slot of class 0 (NOP), or a slot with `in_slot_vld` 0, has `out_exec` 0, takes no tag and leaves both maps unchanged.
- R10: A class-1 slot with equal sources (self-xor) resolves both sources to the register's current tag, takes a new tag and has `out_exec` 1.
- R11: `in_ready` is 0 while a domain's tag need exceeds `fl_s_cnt` or `fl_v_cnt`. A stalled group takes no tag and changes no map entry.
- R12: While `out_valid` is 1 and `out_ready` is 0, the outputs hold their values and `in_ready` is 0.
- R13: `fl_s_pop` and `fl_v_pop` equal the number of tags the accepted group takes from each domain, and are 0 in any cycle with no acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Group presented |
| in_ready | output | 1 | Group can be accepted this cycle |
| in_slot_vld | input | GROUP | Slot holds an instruction |
| in_cls | input | GROUP*3 | Class code per slot |
| in_dst | input | GROUP*AW | Architectural destination per slot |
| in_src1 | input | GROUP*AW | Architectural source 1 per slot |
| in_src2 | input | GROUP*AW | Architectural source 2 per slot |
| in_imm | input | GROUP*IMMW | Immediate per slot |
| fl_s_cnt | input | CW | Scalar tags available (at most GROUP) |
| fl_v_cnt | input | CW | Vector tags available (at most GROUP) |
| fl_s_tag | input | GROUP*PW | Next scalar free tags, oldest first |
| fl_v_tag | input | GROUP*PW | Next vector free tags, oldest first |
| fl_s_pop | output | CW | Scalar tags taken this cycle |
| fl_v_pop | output | CW | Vector tags taken this cycle |
| out_valid | output | 1 | Renamed group present |
| out_ready | input | 1 | Downstream takes the renamed group |
| out_slot_vld | output | GROUP | Registered slot valid |
| out_cls | output | GROUP*3 | Registered class code |
| out_exec | output | GROUP | Slot must go to an execution port |
| out_pdst | output | GROUP*PW | Physical destination tag |
| out_psrc1 | output | GROUP*PW | Physical source-1 tag |
| out_psrc2 | output | GROUP*PW | Physical source-2 tag |
| out_imm | output | GROUP*IMMW | Immediate carried with the slot |

## Verification
The assertions take for granted that the free list offers only distinct, nonzero tags, that its counts never exceed `GROUP`, and that these inputs stay steady while a group waits for `in_ready`. The nonzero-destination check on immediate loads depends on this. The stimulus uses a free-list model that counts up from tag 1 in each domain and advances only by the reported pop counts. Each scenario starts from a fresh reset and allocates far fewer than 63 tags, so no tag wraps round to zero. The counts change only between clock edges, and only in the stall scenarios.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    CL_NOP   = 3'd0,
    CL_SALU  = 3'd1,
    CL_SMOV  = 3'd2,
    CL_SIMM  = 3'd3,
    CL_VALU  = 3'd4,
    CL_VMOV  = 3'd5,
    CL_VZERO = 3'd6,
    CL_VIMM  = 3'd7
  } rn_cls_e;
endpackage

// File: rtl/rn_classify.sv
module rn_classify import rn_pkg::*; #(
  parameter int G  = 8,
  parameter int AW = 5
) (
  input  logic [G-1:0]         slot_vld,
  input  logic [G-1:0][2:0]    cls,
  input  logic [G-1:0][AW-1:0] dst,
  input  logic [G-1:0][AW-1:0] src1,
  output logic [G-1:0]         wr,
  output logic [G-1:0]         vec,
  output logic [G-1:0]         alloc,
  output logic [G-1:0]         exec
);
  rn_cls_e eff [G];

  always_comb begin
    for (int i = 0; i < G; i++) begin
      eff[i] = slot_vld[i] ? rn_cls_e'(cls[i]) : CL_NOP;
      wr[i]  = (eff[i] != CL_NOP);
      vec[i] = eff[i][2];
    end
  end

  // chain: latest earlier vector writer of src1 is a vector move
  always_comb begin
    for (int i = 0; i < G; i++) begin
      logic chain;
      chain = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (eff[j] != CL_NOP && eff[j][2] && dst[j] == src1[i])
          chain = (eff[j] == CL_VMOV);
      end
      unique case (eff[i])
        CL_SALU, CL_VALU: begin alloc[i] = 1'b1;  exec[i] = 1'b1;  end
        CL_SIMM, CL_VIMM: begin alloc[i] = 1'b1;  exec[i] = 1'b0;  end
        CL_VMOV:          begin alloc[i] = chain; exec[i] = chain; end
        default:          begin alloc[i] = 1'b0;  exec[i] = 1'b0;  end
      endcase
    end
  end
endmodule

// File: rtl/rn_alloc.sv
module rn_alloc #(
  parameter int G  = 8,
  parameter int PW = 6
) (
  input  logic [G-1:0]           alloc,
  input  logic [G-1:0]           vec,
  input  logic [G-1:0][PW-1:0]   fl_s_tag,
  input  logic [G-1:0][PW-1:0]   fl_v_tag,
  output logic [G-1:0][PW-1:0]   new_tag,
  output logic [$clog2(G+1)-1:0] need_s,
  output logic [$clog2(G+1)-1:0] need_v
);
  localparam int CW = $clog2(G + 1);
  localparam int IW = (G > 1) ? $clog2(G) : 1;

  always_comb begin
    logic [CW-1:0] cs, cv;
    cs = '0;
    cv = '0;
    for (int i = 0; i < G; i++) begin
      new_tag[i] = '0;
      if (alloc[i] && !vec[i]) begin
        new_tag[i] = fl_s_tag[cs[IW-1:0]];
        cs = cs + CW'(1);
      end else if (alloc[i]) begin
        new_tag[i] = fl_v_tag[cv[IW-1:0]];
        cv = cv + CW'(1);
      end
    end
    need_s = cs;
    need_v = cv;
  end
endmodule

// File: rtl/rn_maptab.sv
module rn_maptab #(
  parameter int AREGS = 32,
  parameter int PW    = 6,
  parameter int G     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [G-1:0]                   we,
  input  logic [G-1:0][$clog2(AREGS)-1:0] wa,
  input  logic [G-1:0][PW-1:0]           wd,
  input  logic [2*G-1:0][$clog2(AREGS)-1:0] ra,
  output logic [2*G-1:0][PW-1:0]         rd
);
  localparam int AW = $clog2(AREGS);

  logic [PW-1:0] tab [AREGS];

  // slots written in order: a later slot to the same register wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < AREGS; k++) tab[k] <= '0;
    end else begin
      for (int i = 0; i < G; i++)
        if (we[i]) tab[wa[i]] <= wd[i];
    end
  end

  for (genvar r = 0; r < 2 * G; r++) begin : g_rd
    assign rd[r] = tab[ra[r][AW-1:0]];
  end
endmodule

// File: rtl/mv_rename.sv
module mv_rename import rn_pkg::*; #(
  parameter int GROUP = 8,
  parameter int AREGS = 32,
  parameter int PHYS  = 64,
  parameter int IMMW  = 16
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  output logic                                in_ready,
  input  logic [GROUP-1:0]                    in_slot_vld,
  input  logic [GROUP-1:0][2:0]               in_cls,
  input  logic [GROUP-1:0][$clog2(AREGS)-1:0] in_dst,
  input  logic [GROUP-1:0][$clog2(AREGS)-1:0] in_src1,
  input  logic [GROUP-1:0][$clog2(AREGS)-1:0] in_src2,
  input  logic [GROUP-1:0][IMMW-1:0]          in_imm,
  input  logic [$clog2(GROUP+1)-1:0]          fl_s_cnt,
  input  logic [$clog2(GROUP+1)-1:0]          fl_v_cnt,
  input  logic [GROUP-1:0][$clog2(PHYS)-1:0]  fl_s_tag,
  input  logic [GROUP-1:0][$clog2(PHYS)-1:0]  fl_v_tag,
  output logic [$clog2(GROUP+1)-1:0]          fl_s_pop,
  output logic [$clog2(GROUP+1)-1:0]          fl_v_pop,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [GROUP-1:0]                    out_slot_vld,
  output logic [GROUP-1:0][2:0]               out_cls,
  output logic [GROUP-1:0]                    out_exec,
  output logic [GROUP-1:0][$clog2(PHYS)-1:0]  out_pdst,
  output logic [GROUP-1:0][$clog2(PHYS)-1:0]  out_psrc1,
  output logic [GROUP-1:0][$clog2(PHYS)-1:0]  out_psrc2,
  output logic [GROUP-1:0][IMMW-1:0]          out_imm
);
  localparam int AW = $clog2(AREGS);
  localparam int PW = $clog2(PHYS);
  localparam int CW = $clog2(GROUP + 1);

  logic [GROUP-1:0]           wr, vec, alloc, exec;
  logic [GROUP-1:0][PW-1:0]   new_tag;
  logic [CW-1:0]              need_s, need_v;
  logic [2*GROUP-1:0][PW-1:0] s_rd, v_rd;
  logic [GROUP-1:0][PW-1:0]   p1, p2, pdst;
  logic [GROUP-1:0]           s_we, v_we;
  logic                       accept;

  rn_classify #(.G(GROUP), .AW(AW)) u_cls (
    .slot_vld(in_slot_vld), .cls(in_cls), .dst(in_dst), .src1(in_src1),
    .wr(wr), .vec(vec), .alloc(alloc), .exec(exec)
  );

  rn_alloc #(.G(GROUP), .PW(PW)) u_alloc (
    .alloc(alloc), .vec(vec), .fl_s_tag(fl_s_tag), .fl_v_tag(fl_v_tag),
    .new_tag(new_tag), .need_s(need_s), .need_v(need_v)
  );

  assign in_ready = (need_s <= fl_s_cnt) && (need_v <= fl_v_cnt) &&
                    (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;
  assign fl_s_pop = accept ? need_s : '0;
  assign fl_v_pop = accept ? need_v : '0;

  // in-order resolution with bypass from earlier slots of the same domain
  always_comb begin
    p1   = '0;
    p2   = '0;
    pdst = '0;
    for (int i = 0; i < GROUP; i++) begin
      p1[i] = vec[i] ? v_rd[i] : s_rd[i];
      p2[i] = vec[i] ? v_rd[GROUP+i] : s_rd[GROUP+i];
      for (int j = 0; j < i; j++) begin
        if (wr[j] && vec[j] == vec[i] && in_dst[j] == in_src1[i]) p1[i] = pdst[j];
        if (wr[j] && vec[j] == vec[i] && in_dst[j] == in_src2[i]) p2[i] = pdst[j];
      end
      if (wr[i]) begin
        unique case (rn_cls_e'(in_cls[i]))
          CL_SMOV:  pdst[i] = p1[i];
          CL_VMOV:  pdst[i] = alloc[i] ? new_tag[i] : p1[i];
          CL_VZERO: pdst[i] = '0;
          default:  pdst[i] = new_tag[i];
        endcase
      end
    end
  end

  for (genvar i = 0; i < GROUP; i++) begin : g_we
    assign s_we[i] = accept && wr[i] && !vec[i];
    assign v_we[i] = accept && wr[i] && vec[i];
  end

  rn_maptab #(.AREGS(AREGS), .PW(PW), .G(GROUP)) u_smap (
    .clk(clk), .rst(rst), .we(s_we), .wa(in_dst), .wd(pdst),
    .ra({in_src2, in_src1}), .rd(s_rd)
  );

  rn_maptab #(.AREGS(AREGS), .PW(PW), .G(GROUP)) u_vmap (
    .clk(clk), .rst(rst), .we(v_we), .wa(in_dst), .wd(pdst),
    .ra({in_src2, in_src1}), .rd(v_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (accept) out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      out_slot_vld <= in_slot_vld;
      out_cls      <= in_cls;
      out_exec     <= exec;
      out_pdst     <= pdst;
      out_psrc1    <= p1;
      out_psrc2    <= p2;
      out_imm      <= in_imm;
    end
  end

  AST_HOLD_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_pdst) && $stable(out_exec)); // R12
  AST_POP_WITHIN_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    fl_s_pop <= fl_s_cnt && fl_v_pop <= fl_v_cnt); // R11

  for (genvar i = 0; i < GROUP; i++) begin : g_chk
    AST_MOVE_ALIASED: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_slot_vld[i] && out_cls[i] == CL_SMOV
      |-> !out_exec[i] && out_pdst[i] == out_psrc1[i]); // R4
    AST_VMOV_SPLIT: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_slot_vld[i] && out_cls[i] == CL_VMOV
      |-> (out_exec[i] ? out_pdst[i] != out_psrc1[i] : out_pdst[i] == out_psrc1[i])); // R6
    AST_IMM_NO_PORT: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_slot_vld[i] && (out_cls[i] == CL_SIMM || out_cls[i] == CL_VIMM)
      |-> !out_exec[i] && out_pdst[i] != '0); // R7
    AST_ZERO_VECTOR: assert property (@(posedge clk) disable iff (rst)
      out_valid && out_slot_vld[i] && out_cls[i] == CL_VZERO
      |-> !out_exec[i] && out_pdst[i] == '0); // R8
    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (rst)
      out_valid && (!out_slot_vld[i] || out_cls[i] == CL_NOP) |-> !out_exec[i]); // R9
  end
endmodule

// File: tb/sim_mv_rename.sv
`timescale 1ns/1ps
module sim_mv_rename;
  localparam int G = 8, AREGS = 32, PHYS = 64, IMMW = 16;
  localparam int AW = $clog2(AREGS), PW = $clog2(PHYS), CW = $clog2(G + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [G-1:0] in_slot_vld = '0, out_slot_vld, out_exec;
  logic [G-1:0][2:0] in_cls = '0, out_cls;
  logic [G-1:0][AW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [G-1:0][IMMW-1:0] in_imm = '0, out_imm;
  logic [CW-1:0] fl_s_cnt = CW'(G), fl_v_cnt = CW'(G), fl_s_pop, fl_v_pop;
  logic [G-1:0][PW-1:0] fl_s_tag, fl_v_tag, out_pdst, out_psrc1, out_psrc2;
  logic [PW-1:0] nxt_s, nxt_v;
  int n_chk = 0, n_fail = 0;
  logic rdy_seen;
  logic [CW-1:0] ps_seen, pv_seen;

  always #2.5 clk = ~clk;

  mv_rename #(.GROUP(G), .AREGS(AREGS), .PHYS(PHYS), .IMMW(IMMW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_slot_vld(in_slot_vld), .in_cls(in_cls), .in_dst(in_dst),
    .in_src1(in_src1), .in_src2(in_src2), .in_imm(in_imm),
    .fl_s_cnt(fl_s_cnt), .fl_v_cnt(fl_v_cnt), .fl_s_tag(fl_s_tag),
    .fl_v_tag(fl_v_tag), .fl_s_pop(fl_s_pop), .fl_v_pop(fl_v_pop),
    .out_valid(out_valid), .out_ready(out_ready), .out_slot_vld(out_slot_vld),
    .out_cls(out_cls), .out_exec(out_exec), .out_pdst(out_pdst),
    .out_psrc1(out_psrc1), .out_psrc2(out_psrc2), .out_imm(out_imm)
  );

  // free-list model: tags count up from 1, advanced by the reported pops
  always @(posedge clk) begin
    if (rst) begin nxt_s <= PW'(1); nxt_v <= PW'(1); end
    else begin nxt_s <= nxt_s + PW'(fl_s_pop); nxt_v <= nxt_v + PW'(fl_v_pop); end
  end
  always_comb
    for (int k = 0; k < G; k++) begin
      fl_s_tag[k] = nxt_s + PW'(k);
      fl_v_tag[k] = nxt_v + PW'(k);
    end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_group();
    in_slot_vld = '0; in_cls = '0; in_dst = '0; in_src1 = '0; in_src2 = '0; in_imm = '0;
  endtask

  task automatic slot(int i, int c, int d, int a, int b, int im);
    in_slot_vld[i] = 1'b1; in_cls[i] = 3'(c); in_dst[i] = AW'(d);
    in_src1[i] = AW'(a); in_src2[i] = AW'(b); in_imm[i] = IMMW'(im);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    fl_s_cnt = CW'(G); fl_v_cnt = CW'(G); clear_group();
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic send();
    @(negedge clk); in_valid = 1'b1;
    #1; rdy_seen = in_ready; ps_seen = fl_s_pop; pv_seen = fl_v_pop;
    @(posedge clk); #1; in_valid = 1'b0; clear_group();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 ready after reset", in_ready, 1);
    slot(0, 1, 5, 3, 4, 0); send();
    chk("R1 psrc1 zero tag", out_psrc1[0], 0);
    chk("R1 psrc2 zero tag", out_psrc2[0], 0);
    chk("R2 pdst first tag", out_pdst[0], 1);
    chk("R2 exec alu", out_exec[0], 1);
    chk("R13 pop one", ps_seen, 1);
  endtask

  task automatic t_bypass();
    do_reset();
    slot(0, 1, 2, 0, 0, 0); slot(1, 1, 3, 2, 2, 0); slot(2, 4, 2, 2, 2, 0);
    slot(3, 1, 2, 2, 3, 0); slot(4, 1, 4, 2, 0, 0); send();
    chk("R2 slot0 pdst", out_pdst[0], 1);
    chk("R3 slot1 src bypass", out_psrc1[1], 1);
    chk("R2 slot1 pdst", out_pdst[1], 2);
    chk("R3 vector not bypassed from scalar", out_psrc1[2], 0);
    chk("R2 vector pdst", out_pdst[2], 1);
    chk("R3 slot3 src1", out_psrc1[3], 1);
    chk("R3 slot3 src2", out_psrc2[3], 2);
    chk("R3 latest writer wins", out_psrc1[4], 3);
    chk("R13 scalar pop", ps_seen, 4);
    chk("R13 vector pop", pv_seen, 1);
    slot(0, 1, 5, 2, 3, 0); send();
    chk("R3 map took latest", out_psrc1[0], 3);
    chk("R3 map src2", out_psrc2[0], 2);
    chk("R2 next tag", out_pdst[0], 5);
  endtask

  task automatic t_moves();
    do_reset();
    slot(0, 1, 1, 0, 0, 0); send();
    slot(0, 2, 2, 1, 0, 0); slot(1, 2, 3, 2, 0, 0); slot(2, 1, 4, 3, 2, 0); send();
    chk("R4 move aliases", out_pdst[0], 1);
    chk("R4 move no exec", out_exec[0], 0);
    chk("R5 chained move", out_pdst[1], 1);
    chk("R5 reader of chain", out_psrc1[2], 1);
    chk("R4 reader of move", out_psrc2[2], 1);
    chk("R4 alu after moves", out_pdst[2], 2);
    chk("R13 moves take no tag", ps_seen, 1);
    slot(0, 1, 6, 3, 0, 0); send();
    chk("R5 map after chain", out_psrc1[0], 1);
    chk("R2 tag sequence", out_pdst[0], 3);
  endtask

  task automatic t_full_moves();
    do_reset();
    fl_s_cnt = '0; fl_v_cnt = '0;
    for (int k = 0; k < 4; k++) slot(k, 2, k + 8, k, 0, 0);
    for (int k = 4; k < 8; k++) slot(k, 5, k + 8, k, 0, 0);
    send();
    chk("R4 eight moves accepted at zero supply", rdy_seen, 1);
    chk("R4 no exec", out_exec, 0);
    chk("R13 no scalar pop", ps_seen, 0);
    chk("R13 no vector pop", pv_seen, 0);
    chk("R6 unchained vector move", out_pdst[7], 0);
    fl_s_cnt = CW'(G); fl_v_cnt = CW'(G);
  endtask

  task automatic t_vchain();
    do_reset();
    slot(0, 4, 1, 0, 0, 0); send();
    slot(0, 5, 2, 1, 0, 0); slot(1, 5, 3, 2, 0, 0); slot(2, 5, 5, 3, 0, 0);
    slot(3, 4, 6, 3, 0, 0); send();
    chk("R6 first vector move eliminated", out_exec[0], 0);
    chk("R6 first vector move alias", out_pdst[0], 1);
    chk("R6 chained vector move executes", out_exec[1], 1);
    chk("R6 chained src", out_psrc1[1], 1);
    chk("R6 chained pdst", out_pdst[1], 2);
    chk("R6 second chain pdst", out_pdst[2], 3);
    chk("R6 second chain exec", out_exec[2], 1);
    chk("R3 vector reader", out_psrc1[3], 2);
    chk("R13 vector pop", pv_seen, 3);
  endtask

  task automatic t_imm();
    do_reset();
    slot(0, 3, 4, 0, 0, 16'h1234); slot(1, 7, 4, 0, 0, 16'hBEEF); send();
    chk("R7 scalar imm pdst", out_pdst[0], 1);
    chk("R7 scalar imm no exec", out_exec[0], 0);
    chk("R7 imm passed", out_imm[0], 32'h1234);
    chk("R7 vector imm pdst", out_pdst[1], 1);
    chk("R7 vector imm passed", out_imm[1], 32'hBEEF);
    chk("R7 scalar pop", ps_seen, 1);
    chk("R7 vector pop", pv_seen, 1);
    slot(0, 1, 9, 4, 0, 0); slot(1, 4, 9, 4, 0, 0); send();
    chk("R7 scalar reader", out_psrc1[0], 1);
    chk("R7 vector reader", out_psrc1[1], 1);
  endtask

  task automatic t_vzero();
    do_reset();
    slot(0, 4, 7, 0, 0, 0); send();
    slot(0, 6, 7, 0, 0, 0); slot(1, 4, 8, 7, 0, 0); send();
    chk("R8 zero tag", out_pdst[0], 0);
    chk("R8 no exec", out_exec[0], 0);
    chk("R8 in-group reader", out_psrc1[1], 0);
    chk("R8 only alu pops", pv_seen, 1);
    slot(0, 4, 9, 7, 0, 0); send();
    chk("R8 map holds zero", out_psrc1[0], 0);
  endtask

  task automatic t_nop();
    do_reset();
    slot(0, 1, 3, 0, 0, 0); send();
    slot(0, 0, 3, 1, 1, 0); slot(1, 1, 3, 1, 1, 0); in_slot_vld[1] = 1'b0; send();
    chk("R9 nop no exec", out_exec[0], 0);
    chk("R9 invalid no exec", out_exec[1], 0);
    chk("R9 no pop", ps_seen, 0);
    slot(0, 1, 4, 3, 0, 0); send();
    chk("R9 map unchanged", out_psrc1[0], 1);
    chk("R9 tag not consumed", out_pdst[0], 2);
  endtask

  task automatic t_xor();
    do_reset();
    slot(0, 1, 1, 0, 0, 0); send();
    slot(0, 1, 1, 1, 1, 0); send();
    chk("R10 src1 dependency", out_psrc1[0], 1);
    chk("R10 src2 dependency", out_psrc2[0], 1);
    chk("R10 new tag", out_pdst[0], 2);
    chk("R10 executes", out_exec[0], 1);
  endtask

  task automatic t_stall();
    do_reset();
    fl_s_cnt = CW'(1);
    slot(0, 1, 5, 0, 0, 0); slot(1, 1, 6, 0, 0, 0);
    @(negedge clk); in_valid = 1'b1; #1;
    chk("R11 short scalar supply", in_ready, 0);
    chk("R13 no pop on stall", fl_s_pop, 0);
    @(posedge clk); #1;
    chk("R11 nothing accepted", out_valid, 0);
    in_valid = 1'b0; clear_group();
    slot(0, 1, 7, 5, 0, 0); send();
    chk("R11 one-tag group accepted", rdy_seen, 1);
    chk("R11 stalled group left map", out_psrc1[0], 0);
    chk("R11 stalled group took no tag", out_pdst[0], 1);
    fl_s_cnt = CW'(G); fl_v_cnt = '0;
    slot(0, 4, 1, 0, 0, 0);
    @(negedge clk); in_valid = 1'b1; #1;
    chk("R11 short vector supply", in_ready, 0);
    @(negedge clk); fl_v_cnt = CW'(1); #1;
    chk("R11 vector supply restored", in_ready, 1);
    chk("R13 vector pop", fl_v_pop, 1);
    @(posedge clk); #1; in_valid = 1'b0; clear_group();
    chk("R11 vector pdst", out_pdst[0], 1);
    fl_v_cnt = CW'(G);
  endtask

  task automatic t_hold();
    do_reset();
    out_ready = 1'b0;
    slot(0, 1, 1, 0, 0, 0); send();
    chk("R12 first accepted", out_pdst[0], 1);
    slot(0, 1, 2, 1, 0, 0);
    @(negedge clk); in_valid = 1'b1; #1;
    chk("R12 ready low when blocked", in_ready, 0);
    @(posedge clk); #1;
    chk("R12 output held valid", out_valid, 1);
    chk("R12 output held pdst", out_pdst[0], 1);
    @(negedge clk); out_ready = 1'b1; #1;
    chk("R12 ready after drain", in_ready, 1);
    @(posedge clk); #1; in_valid = 1'b0; clear_group();
    chk("R12 second pdst", out_pdst[0], 2);
    chk("R12 second src", out_psrc1[0], 1);
  endtask

  initial begin
    t_reset(); t_bypass(); t_moves(); t_full_moves(); t_vchain();
    t_imm(); t_vzero(); t_nop(); t_xor(); t_stall(); t_hold();
    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule